// File: doc/BRIEF.md
# SDRAM Single-Access Bus State Sequencer

This block runs one read or one write to a synchronous DRAM as a fixed run of four bus states. First comes a precharge state, then a row state that opens the row, then two column states that issue the column command and finish the data phase. The timing never changes. No wait states are added and no timing setting can stretch a state. A request is taken only while the SDRAM address space is enabled. The block also produces the system bus clock and a clock for the memory device.

One input clock `clk` runs at four times the bus state rate. Each bus state is four `clk` cycles long, and a 2-bit phase counter marks each cycle within it. This lets the memory clock be shifted by exactly a quarter of a bus state. For PLL factor codes x1 and x2 the memory clock lags the system clock by 90°, which gives a memory that samples on the rising edge a stable setup window. For code x4 the two clocks are in phase. The memory clock drives its output only while `sdclk_en` is high.

The requester holds `req` together with the address, direction and write data until it sees `busy`. It then waits for the one-cycle `done` pulse. On a read, the data returned by the memory is on `rdata` when `done` is high.

Top module: `sdseq_top`

## Requirements
- R1: One bus state lasts four `clk` cycles, counted from reset release. `sys_clk_o` is high in the first two of these cycles and low in the last two.
- R2: `bus_state` changes only at the clock edge that closes a bus state. The codes are 0 idle, 1 precharge, 2 row, 3 column-1 and 4 column-2.
- R3: An accepted request runs precharge, row, column-1 and column-2, each for exactly one bus state, and then returns to idle.
- R4: The command nibble {cs_n, ras_n, cas_n, we_n} depends on the state. Idle is 1111. Precharge is 0010. Row is 0011. Column-1 is 0101 for a read and 0100 for a write. Column-2 is 0111.
- R5: `mem_addr` carries the upper ROW_W bits of the latched address during the row state. During column-1 it carries the lower COL_W bits, zero-extended. In every other state it is zero.
- R6: During column-1 and column-2 of a write, `wdata_o` shows the latched write data; otherwise it is zero. At the edge that closes column-2, a read copies `rd_data_in` into `rdata`. A write leaves `rdata` unchanged. That same edge raises `done` for exactly one `clk` cycle.
- R7: `busy` is high from the edge that accepts a request until the sequence is back in idle. A request made while `busy` is high is ignored.
- R8: A request is accepted only at the edge that closes an idle bus state, and only while `space_en` is high. With `space_en` low the block stays idle.
- R9: With `sdclk_en` high and `pll_mult` at 00 (x1) or 01 (x2), `sdram_clk_o` is high in the second and third cycles of each bus state. It lags `sys_clk_o` by one `clk` cycle.
- R10: With `sdclk_en` high and `pll_mult` at 10 (x4) or 11, `sdram_clk_o` equals `sys_clk_o`.
- R11: With `sdclk_en` low, `sdram_clk_o` is held low.
- R12: During and right after reset the block is idle: `busy` and `done` are low and the command nibble is 1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the bus state rate |
| rst | input | 1 | Synchronous active-high reset |
| pll_mult | input | 2 | PLL factor code: 00 x1, 01 x2, 10 x4, 11 treated as x4 |
| sdclk_en | input | 1 | Enables the memory clock output |
| space_en | input | 1 | SDRAM address space enabled |
| req | input | 1 | Access request, held until accepted |
| req_we | input | 1 | 1 for write, 0 for read |
| req_addr | input | ROW_W+COL_W | Access address, row in the upper bits |
| req_wdata | input | DATA_W | Write data |
| rd_data_in | input | DATA_W | Data returned by the memory |
| sys_clk_o | output | 1 | System bus clock |
| sdram_clk_o | output | 1 | Memory clock |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| mem_addr | output | ROW_W | Multiplexed row/column address |
| wdata_o | output | DATA_W | Write data to the memory |
| rdata | output | DATA_W | Captured read data |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A sequence is in progress |
| bus_state | output | 3 | Current bus state code |

## Verification
The hardest case to reach from the ports is a second request that arrives while a sequence is running. It must leave no trace: the addresses of the running sequence do not change and no new sequence follows. The bench raises `req` with a different address and direction in the middle of the row state. It drops `req` before column-2 ends and checks that the command nibble stays at idle for two bus states afterwards. The bench also holds `req` across several bus-state boundaries with `space_en` low, and finds the acceptance edge from its own count of edges since reset.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

    typedef enum logic [2:0] {
        BS_IDLE = 3'd0,
        BS_PRE  = 3'd1,
        BS_ROW  = 3'd2,
        BS_COL1 = 3'd3,
        BS_COL2 = 3'd4
    } bus_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam int PH_W = 2;

    localparam sd_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_cmd_t CMD_PRECH = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sd_cmd_t CMD_ACT   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_cmd_t CMD_RD    = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
    localparam sd_cmd_t CMD_WR    = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
    localparam sd_cmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    function automatic sd_cmd_t cmd_for(bus_state_e s, logic wr);
        sd_cmd_t c;
        case (s)
            BS_PRE:  c = CMD_PRECH;
            BS_ROW:  c = CMD_ACT;
            BS_COL1: c = wr ? CMD_WR : CMD_RD;
            BS_COL2: c = CMD_NOP;
            default: c = CMD_DESEL;
        endcase
        return c;
    endfunction

    // Codes 00 and 01 pick the quarter-cycle lag; 10 and 11 keep phase.
    function automatic logic clk_lags(logic [1:0] code);
        return ~code[1];
    endfunction

endpackage

// File: rtl/sdseq_clkgen.sv
module sdseq_clkgen
    import sdseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      pll_mult,
    input  logic            sdclk_en,
    output logic [PH_W-1:0] phase,
    output logic            state_end,
    output logic            sys_clk,
    output logic            sd_clk
);
    logic lagged;

    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase + 1'b1;
    end

    assign state_end = &phase;
    assign sys_clk   = ~phase[PH_W-1];
    // High in the second and third quarter: a one-quarter shifted copy.
    assign lagged    = phase[PH_W-1] ^ phase[PH_W-2];
    assign sd_clk    = sdclk_en & (clk_lags(pll_mult) ? lagged : sys_clk);

endmodule

// File: rtl/sdseq_fsm.sv
module sdseq_fsm
    import sdseq_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 9,
    parameter int DATA_W = 16,
    localparam int ADDR_W = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              state_end,
    input  logic              space_en,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] rd_data_in,
    output bus_state_e        state,
    output logic              lat_we,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= BS_IDLE;
            lat_we    <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            rdata     <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state_end) begin
                case (state)
                    BS_IDLE: begin
                        if (req && space_en) begin
                            lat_we    <= req_we;
                            lat_addr  <= req_addr;
                            lat_wdata <= req_wdata;
                            state     <= BS_PRE;
                        end
                    end
                    BS_PRE:  state <= BS_ROW;
                    BS_ROW:  state <= BS_COL1;
                    BS_COL1: state <= BS_COL2;
                    BS_COL2: begin
                        state <= BS_IDLE;
                        done  <= 1'b1;
                        if (!lat_we) rdata <= rd_data_in;
                    end
                    default: state <= BS_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/sdseq_cmd.sv
module sdseq_cmd
    import sdseq_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 9,
    parameter int DATA_W = 16,
    localparam int ADDR_W = ROW_W + COL_W
) (
    input  bus_state_e        state,
    input  logic              lat_we,
    input  logic [ADDR_W-1:0] lat_addr,
    input  logic [DATA_W-1:0] lat_wdata,
    output sd_cmd_t           cmd,
    output logic [ROW_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] wdata_o
);
    logic [ROW_W-1:0] row_part;
    logic [ROW_W-1:0] col_part;

    assign row_part = lat_addr[ADDR_W-1:COL_W];
    assign col_part = ROW_W'(lat_addr[COL_W-1:0]);
    assign cmd      = cmd_for(state, lat_we);

    always_comb begin
        case (state)
            BS_ROW:  mem_addr = row_part;
            BS_COL1: mem_addr = col_part;
            default: mem_addr = '0;
        endcase
        wdata_o = (lat_we && (state == BS_COL1 || state == BS_COL2)) ? lat_wdata : '0;
    end

endmodule

// File: rtl/sdseq_top.sv
module sdseq_top
    import sdseq_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 9,
    parameter int DATA_W = 16,
    localparam int ADDR_W = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        pll_mult,
    input  logic              sdclk_en,
    input  logic              space_en,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] rd_data_in,
    output logic              sys_clk_o,
    output logic              sdram_clk_o,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ROW_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              busy,
    output logic [2:0]        bus_state
);
    logic [PH_W-1:0]   phase_q;
    logic              state_end;
    bus_state_e        state;
    logic              lat_we;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    sd_cmd_t           cmd;

    sdseq_clkgen u_clk (
        .clk       (clk),
        .rst       (rst),
        .pll_mult  (pll_mult),
        .sdclk_en  (sdclk_en),
        .phase     (phase_q),
        .state_end (state_end),
        .sys_clk   (sys_clk_o),
        .sd_clk    (sdram_clk_o)
    );

    sdseq_fsm #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .state_end  (state_end),
        .space_en   (space_en),
        .req        (req),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rd_data_in (rd_data_in),
        .state      (state),
        .lat_we     (lat_we),
        .lat_addr   (lat_addr),
        .lat_wdata  (lat_wdata),
        .rdata      (rdata),
        .done       (done)
    );

    sdseq_cmd #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_cmd (
        .state     (state),
        .lat_we    (lat_we),
        .lat_addr  (lat_addr),
        .lat_wdata (lat_wdata),
        .cmd       (cmd),
        .mem_addr  (mem_addr),
        .wdata_o   (wdata_o)
    );

    assign cs_n      = cmd.cs_n;
    assign ras_n     = cmd.ras_n;
    assign cas_n     = cmd.cas_n;
    assign we_n      = cmd.we_n;
    assign busy      = (state != BS_IDLE);
    assign bus_state = state;

endmodule

// File: rtl/sdseq_checker.sv
module sdseq_checker
    import sdseq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] phase,
    input logic [2:0] bus_state,
    input logic       done,
    input logic       busy,
    input logic       req,
    input logic       space_en,
    input logic       sys_clk_o,
    input logic       sdram_clk_o,
    input logic       sdclk_en,
    input logic [1:0] pll_mult,
    input logic       cs_n
);
    logic warm;

    always_ff @(posedge clk) begin
        if (rst) warm <= 1'b0;
        else     warm <= 1'b1;
    end

    assert_state_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'd3) |=> $stable(bus_state));

    assert_pre_to_row_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_state == BS_PRE && phase == 2'd3) |=> (bus_state == BS_ROW));

    assert_row_to_col_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_state == BS_ROW && phase == 2'd3) |=> (bus_state == BS_COL1));

    assert_col_to_col_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_state == BS_COL1 && phase == 2'd3) |=> (bus_state == BS_COL2));

    assert_done_source_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(bus_state) == BS_COL2 && bus_state == BS_IDLE));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_start_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req && space_en));

    assert_idle_deselect_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_state == BS_IDLE) |-> cs_n);

    assert_clk_lag_R9: assert property (@(posedge clk) disable iff (rst)
        (warm && sdclk_en && !pll_mult[1] && $stable(pll_mult) && $stable(sdclk_en))
            |-> (sdram_clk_o == $past(sys_clk_o)));

    assert_clk_inphase_R10: assert property (@(posedge clk) disable iff (rst)
        (sdclk_en && pll_mult[1]) |-> (sdram_clk_o == sys_clk_o));

    assert_clk_off_R11: assert property (@(posedge clk) disable iff (rst)
        !sdclk_en |-> !sdram_clk_o);

endmodule

bind sdseq_top sdseq_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .phase       (phase_q),
    .bus_state   (bus_state),
    .done        (done),
    .busy        (busy),
    .req         (req),
    .space_en    (space_en),
    .sys_clk_o   (sys_clk_o),
    .sdram_clk_o (sdram_clk_o),
    .sdclk_en    (sdclk_en),
    .pll_mult    (pll_mult),
    .cs_n        (cs_n)
);

// File: tb/tb_sdseq_top.sv
`timescale 1ns/1ps
module tb_sdseq_top;
    localparam int ROW_W  = 12;
    localparam int COL_W  = 9;
    localparam int DATA_W = 16;
    localparam int ADDR_W = ROW_W + COL_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        pll_mult = 2'b00;
    logic              sdclk_en = 1'b0;
    logic              space_en = 1'b1;
    logic              req = 1'b0;
    logic              req_we = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [DATA_W-1:0] rd_data_in = '0;
    logic              sys_clk_o, sdram_clk_o, cs_n, ras_n, cas_n, we_n;
    logic [ROW_W-1:0]  mem_addr;
    logic [DATA_W-1:0] wdata_o, rdata;
    logic              done, busy;
    logic [2:0]        bus_state;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    sdseq_top #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst), .pll_mult(pll_mult), .sdclk_en(sdclk_en),
        .space_en(space_en), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data_in(rd_data_in), .sys_clk_o(sys_clk_o),
        .sdram_clk_o(sdram_clk_o), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .mem_addr(mem_addr), .wdata_o(wdata_o), .rdata(rdata),
        .done(done), .busy(busy), .bus_state(bus_state)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (cyc %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [3:0] nib();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check("R12 cmd in reset", nib(), 4'b1111);
        check("R12 busy in reset", busy, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R12 cmd after reset", nib(), 4'b1111);
        check("R12 busy after reset", busy, 0);
        check("R12 done after reset", done, 0);
        check("R2 state idle after reset", bus_state, 0);
    endtask

    task automatic t_clock(input logic [1:0] code, input logic en);
        pll_mult = code;
        sdclk_en = en;
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            begin
                logic s_exp;
                logic d_exp;
                s_exp = ((cyc % 4) < 2);
                if (!en)          d_exp = 1'b0;
                else if (!code[1]) d_exp = ((cyc % 4) == 1) || ((cyc % 4) == 2);
                else              d_exp = s_exp;
                check("R1 sys clock", sys_clk_o, s_exp);
                if (!en)           check("R11 sdram clock off", sdram_clk_o, d_exp);
                else if (!code[1]) check("R9 sdram clock lag", sdram_clk_o, d_exp);
                else               check("R10 sdram clock in phase", sdram_clk_o, d_exp);
            end
        end
    endtask

    task automatic t_access(input logic we, input logic [ADDR_W-1:0] addr,
                            input logic [DATA_W-1:0] wd, input logic [DATA_W-1:0] rd_val,
                            input logic probe);
        logic [DATA_W-1:0] prev_rdata;
        prev_rdata = rdata;
        req_we = we; req_addr = addr; req_wdata = wd; rd_data_in = rd_val;
        req = 1'b1;
        do @(negedge clk); while ((cyc % 4) != 0);
        req = 1'b0;
        for (int k = 0; k < 16; k++) begin
            if (k > 0) @(negedge clk);
            if (probe && k == 5) begin
                req = 1'b1; req_we = ~we; req_addr = ~addr; req_wdata = ~wd;
            end
            if (probe && k == 12) req = 1'b0;
            check("R7 busy during sequence", busy, 1);
            check("R3 state order", bus_state, 32'(k / 4 + 1));
            case (k / 4)
                0: begin
                    check("R4 precharge cmd", nib(), 4'b0010);
                    check("R5 addr zero in precharge", mem_addr, 0);
                end
                1: begin
                    check("R4 active cmd", nib(), 4'b0011);
                    check("R5 row address", mem_addr, 32'(addr[ADDR_W-1:COL_W]));
                end
                2: begin
                    check("R4 column cmd", nib(), we ? 4'b0100 : 4'b0101);
                    check("R5 column address", mem_addr, 32'(addr[COL_W-1:0]));
                    check("R6 write data col1", wdata_o, we ? 32'(wd) : 0);
                end
                default: begin
                    check("R4 nop in col2", nib(), 4'b0111);
                    check("R6 write data col2", wdata_o, we ? 32'(wd) : 0);
                end
            endcase
            check("R6 no early done", done, 0);
        end
        @(negedge clk);
        check("R6 done pulse", done, 1);
        check("R3 back to idle", bus_state, 0);
        check("R6 read capture", rdata, we ? 32'(prev_rdata) : 32'(rd_val));
        @(negedge clk);
        check("R6 done single cycle", done, 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check("R7 no restart after busy request", nib(), 4'b1111);
            check("R7 idle after sequence", busy, 0);
        end
    endtask

    task automatic t_disabled();
        space_en = 1'b0;
        req_we = 1'b0; req_addr = 21'h1ABCD; req = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R8 no start without space", busy, 0);
            check("R8 no command without space", nib(), 4'b1111);
        end
        req = 1'b0;
        space_en = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_clock(2'b00, 1'b1);
        t_clock(2'b01, 1'b1);
        t_clock(2'b10, 1'b1);
        t_clock(2'b11, 1'b1);
        t_clock(2'b00, 1'b0);
        t_access(1'b0, 21'h15A3C, 16'h0000, 16'hBEEF, 1'b0);
        t_access(1'b1, 21'h0A1F7, 16'h1234, 16'h5555, 1'b0);
        t_access(1'b0, 21'h1FFFF, 16'h0000, 16'hC0DE, 1'b1);
        t_access(1'b1, 21'h00001, 16'hA5A5, 16'h7777, 1'b1);
        t_disabled();
        t_access(1'b0, 21'h10200, 16'h0000, 16'h0F0F, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule